// File: doc/BRIEF.md
# Two-Register I2C Configuration Slave

This block is an I2C target that holds two 8-bit configuration registers. The registers are reached through an internal register pointer. The bus pins are open-drain. The block samples SCL and SDA as inputs and pulls SDA low through a drive-enable output. It never drives SCL.

A master sets the pointer with the first byte after a write address. Any data bytes that follow go into the selected register. When the pointer is zero, a second data byte goes into the second register. The pointer is kept after STOP, so a read is a pointer-only write followed by a fresh START with the read address. When the pointer is zero and the master acknowledges the first byte, the block sends the first register and then the second.

A separate synchronous clear input zeroes both registers at any time. It does not disturb the bus transfer in progress or the pointer. Both register values are always available on parallel outputs.

Top module: `i2c2r_slave`

## Requirements
- R1: After reset both register outputs read 0x00, SDA is released and the pointer selects register 0.
- R2: A write of address (R/W=0), pointer byte 0x01, one data byte and STOP stores the data in register 1 and leaves register 0 alone. The slave pulls SDA low during the ninth clock of each byte. The registers change only on a write or a clear.
- R3: With pointer byte 0x00, the first data byte goes to register 0 and the second to register 1. Every byte is acknowledged. Data bytes beyond the last register are acknowledged and discarded. With pointer 0x01, a second data byte is discarded.
- R4: The pointer survives STOP. A START followed by the address with R/W=1 is acknowledged, and the selected register is returned MSB first. A later read without a new pointer returns the same register.
- R5: With pointer 0x00, a master ACK after the first data byte makes the slave send register 1 next. Any byte after register 1 reads as 0x00.
- R6: After a master NACK the slave keeps SDA released until the next START or STOP. A following read works normally.
- R7: A high level on the clear input makes both registers 0x00 on the next clock. The pointer and any transfer in progress go on unchanged, and later writes in that transfer still land.
- R8: A pointer byte other than 0x00 or 0x01 is acknowledged. Data written with it is dropped, and reads with it return 0x00.
- R9: An address byte whose upper seven bits differ from SLAVE_ADDR gets no ACK. The slave ignores the bus until the next START or STOP, so bytes that follow write nothing.
- R10: A START in the middle of any byte or transaction restarts address reception. This holds even after a partial byte or a rejected address.
- R11: The slave changes its SDA drive only while SCL is low, so SDA is stable for the whole SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on) |
| clear_i | input | 1 | Zeroes both registers on the next clock |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg0_o | output | 8 | Register 0 value (bits 5:0 are the offset code) |
| reg1_o | output | 8 | Register 1 value |

## Verification
The hardest case to reach is a clear that arrives partway through a write, between two acknowledged data bytes. It must zero the registers without resetting the pointer or the byte index. The bench holds SCL low after the first data byte has been acknowledged and pulses clear there. It checks that both outputs are zero, sends a second byte, and expects that byte in register 1. A pointer-free read then confirms that the pointer survived. The restart cases are also awkward to reach. The bench reaches them by sending four bits of a byte, or a rejected address, and then issuing a START with SCL high.

// File: rtl/i2c2r_pkg.sv
package i2c2r_pkg;
   localparam int unsigned NREG = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PTR,
      ST_WDAT,
      ST_ACK,
      ST_RD,
      ST_RACK,
      ST_SKIP
   } link_st_e;
endpackage

// File: rtl/i2c2r_sync.sv
module i2c2r_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ch, sda_ch;
   logic              scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_ch <= '1;
         sda_ch <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ch <= {scl_ch[STAGES-2:0], scl_i};
         sda_ch <= {sda_ch[STAGES-2:0], sda_i};
         scl_q  <= scl_ch[STAGES-1];
         sda_q  <= sda_ch[STAGES-1];
      end
   end

   assign scl_s     = scl_ch[STAGES-1];
   assign sda_s     = sda_ch[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c2r_regs.sv
module i2c2r_regs #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NREG   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear_i,
   input  logic [NREG-1:0]              we_i,
   input  logic [DATA_W-1:0]            wdata_i,
   output logic [NREG-1:0][DATA_W-1:0]  regs_o
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)         regs_o[g] <= '0;
         else if (clear_i)   regs_o[g] <= '0;
         else if (we_i[g])   regs_o[g] <= wdata_i;
      end
   end
endmodule

// File: rtl/i2c2r_link.sv
module i2c2r_link
   import i2c2r_pkg::*;
#(
   parameter logic [6:0]  SLAVE_ADDR = 7'h2C,
   parameter int unsigned DATA_W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sda_s,
   input  logic                         scl_rise,
   input  logic                         scl_fall,
   input  logic                         start_det,
   input  logic                         stop_det,
   input  logic [NREG-1:0][DATA_W-1:0]  regs_i,
   output logic                         sda_oe_o,
   output logic [NREG-1:0]              we_o,
   output logic [DATA_W-1:0]            wdata_o
);
   localparam int unsigned CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
   localparam logic [1:0] IDX_SAT = 2'd2;

   link_st_e          st, ack_next;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sr, tx, ptr;
   logic [1:0]        idx, idx_inc;
   logic              mack;
   logic [NREG-1:0]   sel_cur, sel_next;
   logic [DATA_W-1:0] rd_cur, rd_next;

   function automatic logic [NREG-1:0] sel_of(logic [DATA_W-1:0] p, logic [1:0] i);
      logic [DATA_W:0] t;
      logic [NREG-1:0] s;
      t = {1'b0, p} + {{(DATA_W-1){1'b0}}, i};
      for (int j = 0; j < NREG; j++) s[j] = (t == (DATA_W+1)'(j));
      return s;
   endfunction

   function automatic logic [DATA_W-1:0] rd_of(logic [NREG-1:0] s,
                                                logic [NREG-1:0][DATA_W-1:0] r);
      logic [DATA_W-1:0] v;
      v = '0;
      for (int j = 0; j < NREG; j++) v = v | (r[j] & {DATA_W{s[j]}});
      return v;
   endfunction

   assign idx_inc  = (idx == IDX_SAT) ? idx : idx + 2'd1;
   assign sel_cur  = sel_of(ptr, idx);
   assign sel_next = sel_of(ptr, idx_inc);
   assign rd_cur   = rd_of(sel_cur, regs_i);
   assign rd_next  = rd_of(sel_next, regs_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ack_next <= ST_IDLE;
         cnt      <= '0;
         sr       <= '0;
         tx       <= '0;
         ptr      <= '0;
         idx      <= '0;
         mack     <= 1'b0;
         sda_oe_o <= 1'b0;
         we_o     <= '0;
         wdata_o  <= '0;
      end else begin
         we_o <= '0;
         if (start_det) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_det) begin
            st       <= ST_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_PTR, ST_WDAT: begin
                  if (scl_rise && cnt != CNT_FULL) begin
                     sr  <= {sr[DATA_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     cnt <= '0;
                     if (st == ST_ADDR) begin
                        if (sr[DATA_W-1:1] == SLAVE_ADDR) begin
                           sda_oe_o <= 1'b1;
                           idx      <= '0;
                           st       <= ST_ACK;
                           ack_next <= sr[0] ? ST_RD : ST_PTR;
                        end else begin
                           st <= ST_SKIP;
                        end
                     end else if (st == ST_PTR) begin
                        ptr      <= sr;
                        idx      <= '0;
                        sda_oe_o <= 1'b1;
                        st       <= ST_ACK;
                        ack_next <= ST_WDAT;
                     end else begin
                        we_o     <= sel_cur;
                        wdata_o  <= sr;
                        idx      <= idx_inc;
                        sda_oe_o <= 1'b1;
                        st       <= ST_ACK;
                        ack_next <= ST_WDAT;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     st  <= ack_next;
                     cnt <= '0;
                     if (ack_next == ST_RD) begin
                        tx       <= rd_cur;
                        sda_oe_o <= ~rd_cur[DATA_W-1];
                     end else begin
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == CNT_FULL) begin
                        sda_oe_o <= 1'b0;
                        st       <= ST_RACK;
                     end else begin
                        tx       <= {tx[DATA_W-2:0], 1'b0};
                        sda_oe_o <= ~tx[DATA_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        idx      <= idx_inc;
                        tx       <= rd_next;
                        sda_oe_o <= ~rd_next[DATA_W-1];
                        cnt      <= '0;
                        st       <= ST_RD;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c2r_slave.sv
module i2c2r_slave
   import i2c2r_pkg::*;
#(
   parameter logic [6:0]  SLAVE_ADDR  = 7'h2C,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic [DATA_W-1:0] reg0_o,
   output logic [DATA_W-1:0] reg1_o
);
   if (DATA_W != 8) begin : g_bad_width
      $error("i2c2r_slave: DATA_W must be 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c2r_slave: SYNC_STAGES must be at least 2");
   end
   if (SLAVE_ADDR[6:3] == 4'b0000 || SLAVE_ADDR[6:3] == 4'b1111) begin : g_bad_addr
      $error("i2c2r_slave: SLAVE_ADDR lies in a reserved range");
   end

   logic                        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [NREG-1:0]             we_vec;
   logic [DATA_W-1:0]           wdata;
   logic [NREG-1:0][DATA_W-1:0] regs;

   i2c2r_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .scl_i, .sda_i,
      .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
   );

   i2c2r_link #(.SLAVE_ADDR(SLAVE_ADDR), .DATA_W(DATA_W)) u_link (
      .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
      .regs_i(regs), .sda_oe_o, .we_o(we_vec), .wdata_o(wdata)
   );

   i2c2r_regs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
      .clk, .rst_n, .clear_i, .we_i(we_vec), .wdata_i(wdata), .regs_o(regs)
   );

   assign reg0_o = regs[0];
   assign reg1_o = regs[1];
endmodule

// File: rtl/i2c2r_checker.sv
module i2c2r_checker #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NREG   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear_i,
   input logic              sda_oe_o,
   input logic [DATA_W-1:0] reg0_o,
   input logic [DATA_W-1:0] reg1_o,
   input logic [NREG-1:0]   we_vec,
   input logic              start_det,
   input logic              stop_det,
   input logic              scl_s
);
   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (reg0_o == '0 && reg1_o == '0)); // R7
   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && we_vec == '0) |=> ($stable(reg0_o) && $stable(reg1_o))); // R2
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we_vec)); // R3
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o); // R6
   AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe_o); // R10
   AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_s); // R11
endmodule

bind i2c2r_slave i2c2r_checker #(.DATA_W(DATA_W), .NREG(i2c2r_pkg::NREG)) u_chk (
   .clk, .rst_n, .clear_i, .sda_oe_o, .reg0_o, .reg1_o,
   .we_vec, .start_det, .stop_det, .scl_s
);

// File: tb/test_i2c2r_slave.sv
module test_i2c2r_slave;
   localparam logic [6:0] ADDR = 7'h2C;
   localparam logic [6:0] BAD  = 7'h13;
   localparam int QTR = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear_i = 1'b0;
   logic m_scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe_o;
   logic [7:0] reg0_o, reg1_o;
   wire  sda_line = !(m_low || sda_oe_o);

   int n_chk = 0;
   int n_bad = 0;
   int r11_bad = 0;

   always #2.5 clk = ~clk;

   i2c2r_slave #(.SLAVE_ADDR(ADDR)) i_i2c2r_slave (
      .clk, .rst_n, .clear_i, .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe_o, .reg0_o, .reg1_o
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic qwait;
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start;
      m_low = 1'b0; qwait;
      m_scl = 1'b1; qwait;
      m_low = 1'b1; qwait;
      m_scl = 1'b0; qwait;
   endtask

   task automatic bus_stop;
      m_low = 1'b1; qwait;
      m_scl = 1'b1; qwait;
      m_low = 1'b0; qwait;
   endtask

   task automatic put_bit(input logic b);
      m_low = !b; qwait;
      m_scl = 1'b1; qwait; qwait;
      m_scl = 1'b0; qwait;
   endtask

   task automatic get_bit(output logic b);
      m_low = 1'b0; qwait;
      m_scl = 1'b1; qwait;
      b = sda_line; qwait;
      if (sda_line !== b) r11_bad++;
      m_scl = 1'b0; qwait;
   endtask

   task automatic send(input logic [7:0] d, input logic exp_ack, input string tag);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(a);
      check({tag, " ack"}, {7'd0, !a}, {7'd0, exp_ack});
   endtask

   task automatic recv(output logic [7:0] d, input logic mack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(!mack);
   endtask

   task automatic set_ptr(input logic [7:0] p, input string tag);
      bus_start; send({ADDR, 1'b0}, 1'b1, tag); send(p, 1'b1, tag); bus_stop;
   endtask

   task automatic t_reset;
      check("R1 reg0", reg0_o, 8'h00);
      check("R1 reg1", reg1_o, 8'h00);
      check("R1 sda", {7'd0, sda_oe_o}, 8'h00);
   endtask

   task automatic t_single_write;
      bus_start;
      send({ADDR, 1'b0}, 1'b1, "R2 addr");
      send(8'h01, 1'b1, "R2 ptr");
      send(8'hA5, 1'b1, "R2 data");
      bus_stop;
      check("R2 reg1", reg1_o, 8'hA5);
      check("R2 reg0 kept", reg0_o, 8'h00);
   endtask

   task automatic t_dual_write;
      bus_start;
      send({ADDR, 1'b0}, 1'b1, "R3 addr");
      send(8'h00, 1'b1, "R3 ptr");
      send(8'h3C, 1'b1, "R3 d0");
      send(8'hC7, 1'b1, "R3 d1");
      send(8'h99, 1'b1, "R3 extra");
      bus_stop;
      check("R3 reg0", reg0_o, 8'h3C);
      check("R3 reg1", reg1_o, 8'hC7);
      bus_start;
      send({ADDR, 1'b0}, 1'b1, "R3 addr");
      send(8'h01, 1'b1, "R3 ptr1");
      send(8'h11, 1'b1, "R3 p1d0");
      send(8'h22, 1'b1, "R3 p1d1");
      bus_stop;
      check("R3 reg1 one", reg1_o, 8'h11);
      check("R3 reg0 untouched", reg0_o, 8'h3C);
   endtask

   task automatic t_read_single;
      logic [7:0] d;
      set_ptr(8'h00, "R4 ptr");
      bus_start; send({ADDR, 1'b1}, 1'b1, "R4 addrR");
      recv(d, 1'b0); bus_stop;
      check("R4 read reg0", d, 8'h3C);
      bus_start; send({ADDR, 1'b1}, 1'b1, "R4 addrR2");
      recv(d, 1'b0); bus_stop;
      check("R4 pointer kept", d, 8'h3C);
   endtask

   task automatic t_seq_read;
      logic [7:0] d;
      set_ptr(8'h00, "R5 ptr");
      bus_start; send({ADDR, 1'b1}, 1'b1, "R5 addrR");
      recv(d, 1'b1); check("R5 first", d, 8'h3C);
      recv(d, 1'b1); check("R5 second", d, 8'h11);
      recv(d, 1'b0); check("R5 past end", d, 8'h00);
      bus_stop;
   endtask

   task automatic t_nack;
      logic [7:0] d;
      set_ptr(8'h01, "R6 ptr");
      bus_start; send({ADDR, 1'b1}, 1'b1, "R6 addrR");
      recv(d, 1'b0); check("R6 data", d, 8'h11);
      recv(d, 1'b0); check("R6 released", d, 8'hFF);
      bus_stop;
      bus_start; send({ADDR, 1'b1}, 1'b1, "R6 again");
      recv(d, 1'b0); bus_stop;
      check("R6 reread", d, 8'h11);
   endtask

   task automatic t_clear;
      logic [7:0] d;
      bus_start;
      send({ADDR, 1'b0}, 1'b1, "R7 addr");
      send(8'h00, 1'b1, "R7 ptr");
      send(8'h5A, 1'b1, "R7 d0");
      check("R7 pre reg0", reg0_o, 8'h5A);
      @(negedge clk) clear_i = 1'b1;
      @(negedge clk) clear_i = 1'b0;
      check("R7 clr reg0", reg0_o, 8'h00);
      check("R7 clr reg1", reg1_o, 8'h00);
      send(8'h6B, 1'b1, "R7 d1");
      bus_stop;
      check("R7 reg1 after", reg1_o, 8'h6B);
      check("R7 reg0 after", reg0_o, 8'h00);
      bus_start; send({ADDR, 1'b1}, 1'b1, "R7 addrR");
      recv(d, 1'b1); check("R7 ptr kept r0", d, 8'h00);
      recv(d, 1'b0); check("R7 ptr kept r1", d, 8'h6B);
      bus_stop;
   endtask

   task automatic t_bad_ptr;
      logic [7:0] d;
      bus_start;
      send({ADDR, 1'b0}, 1'b1, "R8 addr");
      send(8'h05, 1'b1, "R8 ptr");
      send(8'hEE, 1'b1, "R8 data");
      bus_stop;
      check("R8 reg0", reg0_o, 8'h00);
      check("R8 reg1", reg1_o, 8'h6B);
      bus_start; send({ADDR, 1'b1}, 1'b1, "R8 addrR");
      recv(d, 1'b0); bus_stop;
      check("R8 read", d, 8'h00);
   endtask

   task automatic t_wrong_addr;
      bus_start;
      send({BAD, 1'b0}, 1'b0, "R9 addr");
      send(8'h00, 1'b0, "R9 ptr");
      send(8'hFF, 1'b0, "R9 data");
      bus_stop;
      check("R9 reg0", reg0_o, 8'h00);
      check("R9 reg1", reg1_o, 8'h6B);
   endtask

   task automatic t_restart;
      bus_start;
      send({BAD, 1'b0}, 1'b0, "R10 bad");
      bus_start;
      send({ADDR, 1'b0}, 1'b1, "R10 addr");
      send(8'h01, 1'b1, "R10 ptr");
      send(8'h42, 1'b1, "R10 data");
      bus_stop;
      check("R10 after rejected", reg1_o, 8'h42);
      bus_start;
      send({ADDR, 1'b0}, 1'b1, "R10 addr2");
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      bus_start;
      send({ADDR, 1'b0}, 1'b1, "R10 addr3");
      send(8'h01, 1'b1, "R10 ptr3");
      send(8'h24, 1'b1, "R10 data3");
      bus_stop;
      check("R10 after partial", reg1_o, 8'h24);
      check("R10 reg0", reg0_o, 8'h00);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
   end

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset;
      t_single_write;
      t_dual_write;
      t_read_single;
      t_seq_read;
      t_nack;
      t_clear;
      t_bad_ptr;
      t_wrong_addr;
      t_restart;
      check("R11 sda steady while scl high", r11_bad[7:0], 8'h00);
      summary;
   end
endmodule